// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked host use an external asynchronous static RAM of 65536 words by 16 bits. The host offers one access at a time on a request/ready handshake: a word address, a write flag, write data and a two-bit lane mask. The controller turns that access into a timed strobe sequence on the memory pins. The memory pins are chip enable, write enable, output enable and one byte enable for each lane, all active low, plus the address. The data bus is split into an input, an output and a driver enable for the tri-state buffer that sits outside the block.

All timing is set in whole clock cycles by parameters. The integrator computes each count as the ceiling of the memory's nanosecond figure divided by the clock period. The counts are the read access wait, the write-enable pulse width and an extra turnaround gap placed before a write that follows a read. Read data comes back with a single-cycle valid pulse. A write whose lane mask is all zero is acknowledged without touching the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. Once an access with a non-zero effect is accepted (`req_valid` and `req_ready` high at a clock edge), `req_ready` stays low until that access has finished.
- R2: Mask bit 0 selects the lower lane (data bits 7:0) and drives `mem_be_n[0]` low. Mask bit 1 selects the upper lane (bits 15:8) and drives `mem_be_n[1]` low. While `mem_ce_n` is low, `mem_be_n` and `mem_addr` hold steady and equal the inverted mask and the address of the accepted request.
- R3: A read holds `mem_ce_n` low, `mem_oe_n` low and `mem_we_n` high for exactly RD_WAIT cycles. `rsp_valid` is high for a single cycle, RD_WAIT+1 cycles after the accepting edge.
- R4: The memory data is sampled on the last read wait cycle. In `rsp_rdata`, a lane whose mask bit is 0 reads as zero.
- R5: A write holds `mem_we_n` low for exactly WR_PULSE cycles, with `mem_ce_n` low and the data drivers enabled. A lane whose mask bit is 0 keeps its byte enable high, so its stored byte is unchanged.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low, and it is high only during a write.
- R7: The data drivers turn on exactly one cycle before `mem_we_n` falls. In that cycle `mem_we_n` is still high and the write data is already valid.
- R8: When a write follows a read, at least 1+TURN_CYC cycles with every strobe deasserted separate the rise of `mem_oe_n` from the rise of `mem_dq_oe`.
- R9: A write whose mask is 0 completes at the accepting edge. `req_ready` stays high, no strobe toggles and the memory contents are unchanged.
- R10: During and after reset, `req_ready` is high, every strobe and byte enable is high, and `mem_dq_oe` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Controller idle and able to take an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle pulse when read data is returned |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 lower lane |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the external data driver |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bench memory model presents valid data only in the final read wait cycle and returns filler bytes on unselected lanes. A controller that samples one cycle early therefore returns filler, and one that forgets to zero masked lanes leaks the filler into the response. A read followed at once by a write measures the idle gap: dropping the turnaround leaves a gap of one cycle where two are required. Single-lane writes are read back as full words, so a design that enables the wrong lane corrupts the neighbouring byte. A zero-mask write is checked for ready staying high, no chip-enable activity and unchanged contents, which exposes a design that strobes with no lane selected.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_READ,
      ST_WSETUP,
      ST_WPULSE
   } ctl_state_e;

   function automatic int max_of3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic [LANES-1:0]        mask,
   input  logic                    active,
   input  logic [LANES*LANE_W-1:0] raw_rd,
   output logic [LANES-1:0]        be_n,
   output logic [LANES*LANE_W-1:0] rd_lanes
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be_n[g] = ~(active & mask[g]);
      assign rd_lanes[g*LANE_W +: LANE_W] =
         mask[g] ? raw_rd[g*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int LANE_W   = 8,
   parameter int RD_WAIT  = 2,
   parameter int WR_PULSE = 1,
   parameter int TURN_CYC = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_write,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic [DATA_W/LANE_W-1:0]    req_mask,
   output logic                        rsp_valid,
   output logic [DATA_W-1:0]           rsp_rdata,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic                        mem_ce_n,
   output logic                        mem_we_n,
   output logic                        mem_oe_n,
   output logic [DATA_W/LANE_W-1:0]    mem_be_n,
   output logic [DATA_W-1:0]           mem_dq_out,
   output logic                        mem_dq_oe,
   input  logic [DATA_W-1:0]           mem_dq_in
);

   localparam int LANES   = DATA_W / LANE_W;
   localparam int CNT_MAX = max_of3(RD_WAIT, WR_PULSE, TURN_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_WAIT - 1);
   localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_PULSE - 1);
   localparam logic [CNT_W-1:0] TURN_LD = (TURN_CYC > 0) ? CNT_W'(TURN_CYC - 1) : '0;
   localparam bit HAS_TURN = (TURN_CYC > 0);

   // elaboration-time parameter checks
   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (RD_WAIT < 1) begin : g_bad_rd
      $error("RD_WAIT must be at least one cycle");
   end
   if (WR_PULSE < 1) begin : g_bad_wr
      $error("WR_PULSE must be at least one cycle");
   end
   if (TURN_CYC < 0) begin : g_bad_turn
      $error("TURN_CYC must not be negative");
   end

   ctl_state_e           state_q, state_d;
   logic [ADDR_W-1:0]    addr_q;
   logic [DATA_W-1:0]    wdata_q;
   logic [LANES-1:0]     mask_q;
   logic                 last_rd_q;
   logic [DATA_W-1:0]    rdata_q;
   logic                 rsp_valid_q;

   logic                 accept, null_wr, take;
   logic                 tmr_load, tmr_done;
   logic [CNT_W-1:0]     tmr_val;
   logic                 rd_act, wr_act, rd_done;
   logic [DATA_W-1:0]    rd_masked;

   assign accept  = req_valid && (state_q == ST_IDLE);
   assign null_wr = req_write && (req_mask == '0);
   assign take    = accept && !null_wr;
   assign rd_act  = (state_q == ST_READ);
   assign wr_act  = (state_q == ST_WSETUP) || (state_q == ST_WPULSE);
   assign rd_done = rd_act && tmr_done;

   // next-state and timer load selection
   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (take) begin
               if (!req_write) begin
                  state_d  = ST_READ;
                  tmr_load = 1'b1;
                  tmr_val  = RD_LD;
               end else if (HAS_TURN && last_rd_q) begin
                  state_d  = ST_TURN;
                  tmr_load = 1'b1;
                  tmr_val  = TURN_LD;
               end else begin
                  state_d = ST_WSETUP;
               end
            end
         end
         ST_TURN: begin
            if (tmr_done) state_d = ST_WSETUP;
         end
         ST_WSETUP: begin
            state_d  = ST_WPULSE;
            tmr_load = 1'b1;
            tmr_val  = WR_LD;
         end
         ST_WPULSE: begin
            if (tmr_done) state_d = ST_IDLE;
         end
         ST_READ: begin
            if (tmr_done) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   sram_wait_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   sram_lane_map #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) i_lanes (
      .mask     (mask_q),
      .active   (rd_act || wr_act),
      .raw_rd   (mem_dq_in),
      .be_n     (mem_be_n),
      .rd_lanes (rd_masked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         wdata_q     <= '0;
         mask_q      <= '0;
         last_rd_q   <= 1'b0;
         rdata_q     <= '0;
         rsp_valid_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         rsp_valid_q <= rd_done;
         if (take) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
         end
         if (rd_done) begin
            rdata_q   <= rd_masked;
            last_rd_q <= 1'b1;
         end else if (state_q == ST_WSETUP) begin
            last_rd_q <= 1'b0;
         end
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign rsp_valid  = rsp_valid_q;
   assign rsp_rdata  = rdata_q;
   assign mem_addr   = addr_q;
   assign mem_ce_n   = !(rd_act || wr_act);
   assign mem_oe_n   = !rd_act;
   assign mem_we_n   = (state_q != ST_WPULSE);
   assign mem_dq_out = wdata_q;
   assign mem_dq_oe  = wr_act;

   // ---------------- assertions ----------------
   a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !(req_write && req_mask == '0)) |=> !req_ready);

   a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_be_n) && $stable(mem_addr)));

   a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_oe_n && mem_we_n));

   a_r3_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r5_drive_during_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_dq_oe && !mem_ce_n));

   a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r7_setup_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(mem_dq_oe) && $stable(mem_dq_out)));

   a_r8_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> $past(mem_oe_n));

   a_r9_null_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && req_mask == '0) |=> (req_ready && mem_ce_n));

   a_r10_reset_idle: assert property (@(posedge clk)
      !rst_n |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int RD_WAIT    = 3;
   localparam int WR_PULSE   = 2;
   localparam int TURN_CYC   = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [15:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_be_n;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_lane_ctrl #(
      .RD_WAIT  (RD_WAIT),
      .WR_PULSE (WR_PULSE),
      .TURN_CYC (TURN_CYC)
   ) i_sram_lane_ctrl (
      .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr,
      .req_wdata, .req_mask, .rsp_valid, .rsp_rdata, .mem_addr,
      .mem_ce_n, .mem_we_n, .mem_oe_n, .mem_be_n, .mem_dq_out,
      .mem_dq_oe, .mem_dq_in
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [15:0] sim_mem [int unsigned];
   logic [15:0] shadow  [int unsigned];
   int          rd_age = 0;
   logic        reading;
   logic [15:0] stored;

   assign reading = !mem_ce_n && !mem_oe_n && mem_we_n;
   assign stored  = sim_mem.exists(int'(mem_addr)) ? sim_mem[int'(mem_addr)] : 16'h0000;

   always_comb begin
      if (reading && rd_age >= RD_WAIT - 1) begin
         mem_dq_in[7:0]  = mem_be_n[0] ? 8'hA5 : stored[7:0];
         mem_dq_in[15:8] = mem_be_n[1] ? 8'hA5 : stored[15:8];
      end else begin
         mem_dq_in = 16'hDEAD;
      end
   end

   always @(posedge clk) begin
      rd_age <= reading ? rd_age + 1 : 0;
      if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
         logic [15:0] w;
         w = stored;
         if (!mem_be_n[0]) w[7:0]  = mem_dq_out[7:0];
         if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
         sim_mem[int'(mem_addr)] = w;
      end
   end

   // ---------------- protocol monitor ----------------
   logic [1:0] cur_mask = '0;
   int  we_run = 0, pre_cnt = 0, since_oe = 0, ce_cycles = 0;
   bit  after_rd = 1'b0, prev_oe = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe && !mem_oe_n)
            chk(1'b0, "R6 driver with output enable", 1, 0);
         if (!mem_ce_n) begin
            ce_cycles++;
            chk(mem_be_n == ~cur_mask, "R2 byte enables", 32'(mem_be_n), 32'(~cur_mask));
         end
         if (!mem_we_n) begin
            if (we_run == 0)
               chk(pre_cnt == 1, "R7 setup cycles", pre_cnt, 1);
            we_run++;
         end else begin
            if (we_run != 0) begin
               chk(we_run == WR_PULSE, "R5 pulse width", we_run, WR_PULSE);
               pre_cnt = 0;
            end
            we_run = 0;
            if (mem_dq_oe) pre_cnt++;
         end
         if (!mem_oe_n) begin
            since_oe = 0;
            after_rd = 1'b1;
         end else begin
            since_oe++;
         end
         if (mem_dq_oe && !prev_oe && after_rd) begin
            chk(since_oe - 1 >= 1 + TURN_CYC, "R8 turnaround gap", since_oe - 1, 1 + TURN_CYC);
            after_rd = 1'b0;
         end
         prev_oe = mem_dq_oe;
      end
   end

   // ---------------- scoreboard ----------------
   logic [15:0] exp_q [$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected response", 32'(rsp_rdata), 0);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(rsp_rdata == e, "R4 read data", 32'(rsp_rdata), 32'(e));
         end
      end
   end

   function automatic logic [15:0] shadow_rd(input logic [15:0] a);
      return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
   endfunction

   task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      req_mask  = m;
      if (!(wr && m == 2'b00)) cur_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
      logic [15:0] s;
      s = shadow_rd(a);
      if (m[0]) s[7:0]  = d[7:0];
      if (m[1]) s[15:8] = d[15:8];
      shadow[int'(a)] = s;
      issue(1'b1, a, d, m);
      chk(req_ready == 1'b0, "R1 busy during write", 32'(req_ready), 0);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic do_read(input logic [15:0] a, input logic [1:0] m);
      logic [15:0] e;
      int n;
      e = shadow_rd(a);
      if (!m[0]) e[7:0]  = 8'h00;
      if (!m[1]) e[15:8] = 8'h00;
      exp_q.push_back(e);
      issue(1'b0, a, 16'h0000, m);
      chk(req_ready == 1'b0, "R1 busy during read", 32'(req_ready), 0);
      n = 1;
      while (!rsp_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk(n == RD_WAIT + 1, "R3 read latency", n, RD_WAIT + 1);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int ce_before;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1 && mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11
          && !mem_dq_oe && !rsp_valid, "R10 reset state",
          {26'd0, req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 32'h3C);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && mem_ce_n, "R10 idle after reset", 32'(req_ready), 1);

      // word accesses
      do_write(16'h0010, 16'h1234, 2'b11);
      do_write(16'h0020, 16'hABCD, 2'b11);
      do_read (16'h0010, 2'b11);
      do_read (16'h0020, 2'b11);

      // single-lane writes (R5 unselected lane untouched)
      do_write(16'h0010, 16'h55EE, 2'b01);
      do_write(16'h0020, 16'h9900, 2'b10);
      do_read (16'h0010, 2'b11);
      do_read (16'h0020, 2'b11);

      // single-lane reads (R4 zero on unselected lane)
      do_read (16'h0010, 2'b01);
      do_read (16'h0020, 2'b10);

      // zero-mask write (R9)
      ce_before = ce_cycles;
      issue(1'b1, 16'h0010, 16'hFFFF, 2'b00);
      chk(req_ready == 1'b1, "R9 ready stays high", 32'(req_ready), 1);
      repeat (4) @(negedge clk);
      chk(ce_cycles == ce_before, "R9 no strobes", ce_cycles, ce_before);
      do_read (16'h0010, 2'b11);

      // read immediately followed by write (R8), then extremes of the address range
      do_read (16'h0020, 2'b11);
      do_write(16'hFFFF, 16'hC3C3, 2'b11);
      do_read (16'hFFFF, 2'b11);
      do_write(16'h0000, 16'h0F0F, 2'b11);
      do_read (16'h0000, 2'b11);
      do_read (16'h0300, 2'b11);

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule